// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM of 32,768 bytes. The RAM has active-low select, write and output-enable strobes and one shared bidirectional byte bus. The host issues one access at a time through a valid/ready handshake that carries a 15-bit address, a write flag and a write byte. The controller then produces the strobe sequence the RAM needs and returns the read byte on its own port.

Every analog interval is a parameter in nanoseconds, alongside a parameter for the clock period. Each interval becomes a whole number of cycles, rounded up. Before a write, output enable is raised first and held high for the RAM's output-turn-off interval. Only then are the controller's own data drivers enabled. The shorter write-pulse rating can be used because output enable is already inactive, and the shared lines are never driven from both ends. The bus is split at the ports into an output byte, a drive enable and an input byte, and the pad ring combines them.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is low and right after it, select, write enable and output enable are all high, the data drive enable is low and ready is high.
- R2: A read holds select low, output enable low and write enable high for ACC cycles, where ACC is the access time divided by the clock period and rounded up. Ready returns exactly ACC cycles after the accepting edge, and the read port then carries the byte stored at the requested address.
- R3: The read port keeps the last read byte through later writes and idle cycles, and changes only when another read completes.
- R4: A write stores the write byte at the requested address. Write enable stays low for exactly WP cycles, where WP is the larger of the short write-pulse time and the data-setup time, divided by the clock period and rounded up.
- R5: The data drive enable is never high while output enable is low. It rises only after output enable has been high for at least OFF cycles (output-turn-off time, rounded up).
- R6: The address and write byte stay stable during write enable low and for one full cycle after write enable rises. A write returns ready OFF+WP+1 cycles after the accepting edge.
- R7: Ready is high only when the controller is idle, with select high. It is low on every cycle of an access.
- R8: Write enable is low only while select is low. Output enable is low only while select is low and write enable is high.
- R9: All 15 address bits reach the RAM, so address 0x0000 and address 0x7FFF hold independent bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host requests an access |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 15 | Word address |
| reqWdata | input | 8 | Byte to write |
| reqReady | output | 1 | Controller idle, request accepted on this edge if valid |
| rdData | output | 8 | Byte from the last completed read |
| sramAddr | output | 15 | RAM address lines |
| sramCsN | output | 1 | RAM select, active low |
| sramWeN | output | 1 | RAM write enable, active low |
| sramOeN | output | 1 | RAM output enable, active low |
| sramDqOut | output | 8 | Byte the controller drives onto the data lines |
| sramDqOe | output | 1 | Controller drives the data lines when high |
| sramDqIn | input | 8 | Byte sampled from the data lines |

## Verification
The bench keeps the 50 MHz clock but sets the notional clock period to 4 ns, which gives ACC = 3, OFF = 2 and WP = 3. With these values the bench covers an interval that divides exactly (12 ns access), two that round up (6 ns turn-off, 9 ns pulse), and multi-cycle counting in every state. At the default period every interval is one cycle and the counters are never exercised. With the longer windows, the bench can measure read and write latency, the width of the write-enable pulse and the output-enable-high run before each drive, and see each of them differ from any off-by-one variant.

// File: rtl/asram_pkg.sv
package asram_pkg;

  // Strobe bundle from control to datapath; pin levels are for the coming cycle.
  typedef struct packed {
    logic csN;
    logic weN;
    logic oeN;
    logic drive;
    logic load;
    logic capture;
  } strobe_t;

  // Nanoseconds to whole clock cycles, rounded up, never below one.
  function automatic int unsigned nsToCyc(input int unsigned ns, input int unsigned clkNs);
    int unsigned c;
    c = (ns + clkNs - 1) / clkNs;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned maxU(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_ctrl_fsm.sv
module asram_ctrl_fsm
  import asram_pkg::*;
#(
  parameter int unsigned ACC_CYC = 1,
  parameter int unsigned OFF_CYC = 1,
  parameter int unsigned WP_CYC  = 1,
  parameter int unsigned CNT_W   = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t strobes
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RACC, ST_WOFF, ST_WPULSE, ST_WHOLD
  } state_t;

  localparam logic [CNT_W-1:0] ACC_LAST = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] OFF_LAST = CNT_W'(OFF_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LAST  = CNT_W'(WP_CYC - 1);

  state_t state, stateD;
  logic [CNT_W-1:0] cnt, cntD;
  logic accept, cntDone;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqReady && reqValid;
  assign cntDone  = (cnt == '0);

  always_comb begin
    stateD = state;
    cntD   = cnt;
    case (state)
      ST_IDLE: if (accept) begin
        stateD = reqWrite ? ST_WOFF : ST_RACC;
        cntD   = reqWrite ? OFF_LAST : ACC_LAST;
      end
      ST_RACC: begin
        if (cntDone) stateD = ST_IDLE;
        else cntD = cnt - 1'b1;
      end
      ST_WOFF: begin
        if (cntDone) begin
          stateD = ST_WPULSE;
          cntD   = WP_LAST;
        end else cntD = cnt - 1'b1;
      end
      ST_WPULSE: begin
        if (cntDone) stateD = ST_WHOLD;
        else cntD = cnt - 1'b1;
      end
      ST_WHOLD: stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateD;
      cnt   <= cntD;
    end
  end

  // Pin levels follow the state being entered, so the pins and the state change on the same edge.
  always_comb begin
    strobes.csN     = (stateD == ST_IDLE);
    strobes.oeN     = (stateD != ST_RACC);
    strobes.weN     = (stateD != ST_WPULSE);
    strobes.drive   = (stateD == ST_WPULSE) || (stateD == ST_WHOLD);
    strobes.load    = accept;
    strobes.capture = (state == ST_RACC) && cntDone;
  end

  // R7
  property readyOnlyIdleProp;
    @(posedge clk) disable iff (!rstN) $past(accept) |-> !reqReady;
  endproperty
  ready_idle_chk: assert property (readyOnlyIdleProp);

endmodule

// File: rtl/asram_ctrl_dp.sv
module asram_ctrl_dp
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WP_CYC = 1,
  parameter int unsigned CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCsN,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  input  logic [DATA_W-1:0] sramDqIn
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sramCsN  <= 1'b1;
      sramWeN  <= 1'b1;
      sramOeN  <= 1'b1;
      sramDqOe <= 1'b0;
    end else begin
      sramCsN  <= strobes.csN;
      sramWeN  <= strobes.weN;
      sramOeN  <= strobes.oeN;
      sramDqOe <= strobes.drive;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sramAddr  <= '0;
      sramDqOut <= '0;
      rdData    <= '0;
    end else begin
      if (strobes.load) begin
        sramAddr  <= reqAddr;
        sramDqOut <= reqWdata;
      end
      if (strobes.capture) rdData <= sramDqIn;
    end
  end

  // Checker: length of each write-enable low pulse.
  logic [CNT_W-1:0] weLowRun;
  always_ff @(posedge clk) begin
    if (!rstN) weLowRun <= '0;
    else if (!sramWeN) weLowRun <= weLowRun + 1'b1;
    else weLowRun <= '0;
  end

  // R4
  property wePulseProp;
    @(posedge clk) disable iff (!rstN) $rose(sramWeN) |-> (weLowRun == CNT_W'(WP_CYC));
  endproperty
  we_pulse_chk: assert property (wePulseProp);

  // R5
  property noContentionProp;
    @(posedge clk) disable iff (!rstN) sramDqOe |-> sramOeN;
  endproperty
  no_contention_chk: assert property (noContentionProp);

  // R6
  property holdAfterWeProp;
    @(posedge clk) disable iff (!rstN)
      ($past(!sramWeN) && !$past(!rstN)) |-> ($stable(sramAddr) && $stable(sramDqOut));
  endproperty
  hold_after_we_chk: assert property (holdAfterWeProp);

  // R8
  property weNeedsCsProp;
    @(posedge clk) disable iff (!rstN) !sramWeN |-> !sramCsN;
  endproperty
  we_needs_cs_chk: assert property (weNeedsCsProp);

  // R8
  property oeReadOnlyProp;
    @(posedge clk) disable iff (!rstN) !sramOeN |-> (!sramCsN && sramWeN);
  endproperty
  oe_read_only_chk: assert property (oeReadOnlyProp);

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W   = 15,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CLK_NS   = 20,
  parameter int unsigned T_ACC_NS = 12,
  parameter int unsigned T_OFF_NS = 6,
  parameter int unsigned T_WP_NS  = 9,
  parameter int unsigned T_DSU_NS = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCsN,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  input  logic [DATA_W-1:0] sramDqIn
);

  localparam int unsigned ACC_CYC = nsToCyc(T_ACC_NS, CLK_NS);
  localparam int unsigned OFF_CYC = nsToCyc(T_OFF_NS, CLK_NS);
  localparam int unsigned WP_CYC  = nsToCyc(maxU(T_WP_NS, T_DSU_NS), CLK_NS);
  localparam int unsigned MAX_CYC = maxU(maxU(ACC_CYC, OFF_CYC), WP_CYC);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 2);

  strobe_t strobes;

  asram_ctrl_fsm #(
    .ACC_CYC(ACC_CYC), .OFF_CYC(OFF_CYC), .WP_CYC(WP_CYC), .CNT_W(CNT_W)
  ) fsm_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .strobes(strobes)
  );

  asram_ctrl_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WP_CYC(WP_CYC), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rdData(rdData), .sramAddr(sramAddr),
    .sramCsN(sramCsN), .sramWeN(sramWeN), .sramOeN(sramOeN),
    .sramDqOut(sramDqOut), .sramDqOe(sramDqOe), .sramDqIn(sramDqIn)
  );

  // R7
  property readyDeselectProp;
    @(posedge clk) disable iff (!rstN) reqReady |-> sramCsN;
  endproperty
  ready_deselect_chk: assert property (readyDeselectProp);

endmodule

// File: tb/asram_ctrl_tb_top.sv
module asram_ctrl_tb_top;

  localparam int CLK_NS = 4;
  localparam int ACC = 3;   // 12/4
  localparam int OFF = 2;   // ceil(6/4)
  localparam int WP  = 3;   // ceil(max(9,7)/4)

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [14:0] reqAddr = '0;
  logic [7:0] reqWdata = '0;
  logic reqReady;
  logic [7:0] rdData, sramDqOut, sramDqIn;
  logic [14:0] sramAddr;
  logic sramCsN, sramWeN, sramOeN, sramDqOe;

  always #10 clk = ~clk;

  asram_ctrl #(.CLK_NS(CLK_NS)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady), .rdData(rdData),
    .sramAddr(sramAddr), .sramCsN(sramCsN), .sramWeN(sramWeN), .sramOeN(sramOeN),
    .sramDqOut(sramDqOut), .sramDqOe(sramDqOe), .sramDqIn(sramDqIn)
  );

  // Behavioural RAM: stores on the rising write strobe while selected.
  logic [7:0] mem [0:32767];
  always @(posedge sramWeN) if (!sramCsN) mem[sramAddr] <= sramDqOut;
  assign sramDqIn = (!sramCsN && sramWeN && !sramOeN) ? mem[sramAddr] : 8'h00;

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Pin monitor sampled between edges.
  int oeHighRun = 0, weRun = 0, lastWeRun = 0;
  logic prevWeLow = 1'b0;
  logic [14:0] prevAddr;
  logic [7:0] prevDq;
  bit monOn = 1'b0;
  always @(negedge clk) if (monOn) begin
    if (sramDqOe && (!sramOeN || oeHighRun < OFF))
      chk(1'b0, "R5 drive before output turn-off", oeHighRun, OFF);
    if ((!sramWeN && sramCsN) || (!sramOeN && (sramCsN || !sramWeN)))
      chk(1'b0, "R8 strobe combination", {sramCsN, sramWeN, sramOeN}, 0);
    if (prevWeLow && (sramAddr != prevAddr || sramDqOut != prevDq))
      chk(1'b0, "R6 address/data hold", sramAddr, prevAddr);
    if (reqReady && !sramCsN) chk(1'b0, "R7 ready while selected", 1, 0);
    if (!sramWeN) weRun++;
    else if (weRun != 0) begin lastWeRun = weRun; weRun = 0; end
    oeHighRun = sramOeN ? oeHighRun + 1 : 0;
    prevWeLow = !sramWeN;
    prevAddr = sramAddr;
    prevDq = sramDqOut;
  end

  // One access; returns cycles from the accepting edge until ready is back.
  task automatic access(input bit wr, input logic [14:0] a, input logic [7:0] d, output int lat);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    lat = 0;
    while (!reqReady && lat < 100) begin
      lat++;
      @(negedge clk);
    end
  endtask

  typedef struct packed { bit wr; logic [14:0] a; logic [7:0] d; } vec_t;
  localparam vec_t VECS [0:9] = '{
    '{1'b1, 15'h0000, 8'hA5}, '{1'b1, 15'h7FFF, 8'h5A}, '{1'b1, 15'h1234, 8'h3C},
    '{1'b0, 15'h0000, 8'hA5}, '{1'b0, 15'h7FFF, 8'h5A}, '{1'b0, 15'h1234, 8'h3C},
    '{1'b1, 15'h1234, 8'hC3}, '{1'b0, 15'h1234, 8'hC3},
    '{1'b1, 15'h4000, 8'hFF}, '{1'b0, 15'h4000, 8'hFF}
  };

  initial begin
    int lat;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sramCsN && sramWeN && sramOeN && !sramDqOe && reqReady, "R1 reset levels",
        {sramCsN, sramWeN, sramOeN, sramDqOe, reqReady}, 5'b11101);
    rstN = 1'b1;
    @(negedge clk);
    chk(sramCsN && sramWeN && sramOeN && !sramDqOe && reqReady, "R1 after reset",
        {sramCsN, sramWeN, sramOeN, sramDqOe, reqReady}, 5'b11101);
    monOn = 1'b1;

    for (int i = 0; i < 10; i++) begin
      access(VECS[i].wr, VECS[i].a, VECS[i].d, lat);
      if (VECS[i].wr) begin
        chk(lat == OFF + WP + 1, "R6 write latency", lat, OFF + WP + 1);
        chk(lastWeRun == WP, "R4 write pulse width", lastWeRun, WP);
      end else begin
        chk(lat == ACC, "R2 read latency", lat, ACC);
        chk(rdData == VECS[i].d, "R2 read data", rdData, VECS[i].d);
      end
    end

    // R9: both ends of the address range hold independent bytes.
    chk(mem[15'h0000] == 8'hA5 && mem[15'h7FFF] == 8'h5A, "R9 address extremes",
        mem[15'h7FFF], 8'h5A);
    // R4: stored byte after a write.
    chk(mem[15'h4000] == 8'hFF, "R4 stored byte", mem[15'h4000], 8'hFF);

    // R3: read data survives writes and idle time.
    access(1'b1, 15'h0000, 8'h11, lat);
    repeat (5) @(negedge clk);
    chk(rdData == 8'hFF, "R3 read data held", rdData, 8'hFF);
    access(1'b0, 15'h0000, 8'h00, lat);
    chk(rdData == 8'h11, "R3 updated by next read", rdData, 8'h11);

    // R7: ready low through a read.
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 15'h7FFF;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk(!reqReady && !sramCsN && !sramOeN, "R7 busy during read", reqReady, 0);
    repeat (ACC) @(negedge clk);
    chk(reqReady && rdData == 8'h5A, "R2 read after busy", rdData, 8'h5A);

    // R5: read immediately followed by a write (monitor checks turn-off window).
    access(1'b0, 15'h1234, 8'h00, lat);
    access(1'b1, 15'h1235, 8'h77, lat);
    chk(mem[15'h1235] == 8'h77, "R5 write after read", mem[15'h1235], 8'h77);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule